// File: doc/BRIEF.md
# Byte/Word Load-Store Data Aligner

This block connects a 32-bit register file to a byte-addressed 32-bit data memory. It handles two transfer sizes, an 8-bit byte and a 32-bit word. An external pin picks little-endian or big-endian lane numbering for each request.

For a store, it forms the word-aligned bus address and steers the register data onto the bus. It also produces one write enable per byte lane. For a load, it issues the request, and in the following cycle it takes the returned bus word. From that word it extracts either the whole word or a single byte. A byte is delivered in bits 7:0 with the upper bits cleared.

A word request whose address is not a multiple of four is flagged as misaligned and is not issued. The block computes no addresses and has no handshake beyond a fixed one-cycle read response.

Top module: `lsa_aligner`

## Requirements
- R1: `mem_addr` equals `ea` with bits 1:0 forced to zero, for every request.
- R2: An aligned word store (`req_word`=1, `ea[1:0]`=00) drives `mem_be`=1111 and `mem_wdata`=`st_data` unchanged.
- R3: A word request with `ea[1:0]`≠00 raises `misalign`, keeps `mem_be`=0000 and keeps `mem_req` low. A byte request never raises `misalign`.
- R4: A byte store puts `st_data[7:0]` on all four byte lanes of `mem_wdata`.
- R5: With `big_endian`=0, a byte store enables only lane `ea[1:0]`. Lane k is `mem_be[k]` and bus bits 8k+7:8k.
- R6: With `big_endian`=1, a byte store enables only lane 3−`ea[1:0]`, so offset 0 uses bits 31:24.
- R7: A load drives `mem_be`=0000. Any request that is not misaligned drives `mem_req`=1.
- R8: With `big_endian`=0, a byte load sets `ld_valid` one cycle later. `ld_data` is then lane `ea[1:0]` of `mem_rdata`, zero-extended.
- R9: With `big_endian`=1, a byte load returns lane 3−`ea[1:0]` of `mem_rdata`, zero-extended, one cycle later.
- R10: An aligned word load returns `mem_rdata` unchanged on `ld_data` one cycle later with `ld_valid`=1. `ld_valid` is high only in the cycle after an issued load.
- R11: `ld_valid` is low while in reset and in the first cycle after it. `ld_data` is zero whenever `ld_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word, 0 = byte |
| big_endian | input | 1 | Lane numbering select |
| ea | input | 32 | Byte effective address |
| st_data | input | 32 | Store data from the register file |
| mem_rdata | input | 32 | Memory read word, valid one cycle after a load |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_req | output | 1 | Access issued to memory |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Store data placed on the bus |
| misalign | output | 1 | Misaligned word request |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Zero-extended load result |

## Verification
The bench builds the block with its default widths: a 32-bit address and a 32-bit data bus, which give four byte lanes. This configuration reaches every lane offset in both endianness settings, and it covers misaligned word requests at offsets 1, 2 and 3. It also reaches the one-cycle load return, including back-to-back loads where a store or an idle cycle falls between them.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_e;
endpackage

// File: rtl/lsa_lane_dec.sv
module lsa_lane_dec #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic              req_valid,
  input  logic              req_store,
  input  lsa_pkg::xfer_e    xfer,
  input  logic              big_endian,
  input  logic [ADDR_W-1:0] ea,
  output logic [$clog2(LANES)-1:0] lane,
  output logic              misalign,
  output logic              issue,
  output logic [LANES-1:0]  wr_en,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int LSB_W = $clog2(LANES);
  localparam logic [LSB_W-1:0] LAST_LANE = LSB_W'(LANES - 1);

  // physical bus lane for a byte offset under the chosen ordering
  function automatic logic [LSB_W-1:0] phys_lane(input logic [LSB_W-1:0] off,
                                                 input logic big);
    return big ? (LAST_LANE - off) : off;
  endfunction

  logic [LSB_W-1:0] offset;
  logic             is_word;
  logic             store_issue;

  assign offset      = ea[LSB_W-1:0];
  assign is_word     = (xfer == lsa_pkg::XFER_WORD);
  assign lane        = phys_lane(offset, big_endian);
  assign misalign    = req_valid & is_word & (|offset);
  assign issue       = req_valid & ~misalign;
  assign store_issue = issue & req_store;
  assign word_addr   = {ea[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};

  for (genvar g = 0; g < LANES; g++) begin : g_en
    assign wr_en[g] = store_issue & (is_word | (lane == LSB_W'(g)));
  end
endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path #(
  parameter int DATA_W = 32
) (
  input  lsa_pkg::xfer_e    xfer,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] wdata
);
  localparam int LANES = DATA_W / lsa_pkg::BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata[g*lsa_pkg::BYTE_W +: lsa_pkg::BYTE_W] =
      (xfer == lsa_pkg::XFER_WORD) ? st_data[g*lsa_pkg::BYTE_W +: lsa_pkg::BYTE_W]
                                   : st_data[lsa_pkg::BYTE_W-1:0];
  end
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path #(
  parameter int DATA_W = 32,
  parameter int LSB_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  lsa_pkg::xfer_e    xfer,
  input  logic [LSB_W-1:0]  lane,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  localparam int BW = lsa_pkg::BYTE_W;

  logic             vld_q;
  lsa_pkg::xfer_e   xfer_q;
  logic [LSB_W-1:0] lane_q;

  function automatic logic [DATA_W-1:0] shape(input logic [DATA_W-1:0] word,
                                              input lsa_pkg::xfer_e x,
                                              input logic [LSB_W-1:0] ln);
    if (x == lsa_pkg::XFER_WORD) return word;
    return {{(DATA_W-BW){1'b0}}, word[ln*BW +: BW]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      xfer_q <= lsa_pkg::XFER_BYTE;
      lane_q <= '0;
    end else begin
      vld_q <= capture;
      if (capture) begin
        xfer_q <= xfer;
        lane_q <= lane;
      end
    end
  end

  assign ld_valid = vld_q;
  assign ld_data  = vld_q ? shape(mem_rdata, xfer_q, lane_q) : '0;
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_word,
  input  logic              big_endian,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_req,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              misalign,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  localparam int LANES = DATA_W / lsa_pkg::BYTE_W;
  localparam int LSB_W = $clog2(LANES);

  lsa_pkg::xfer_e   xfer;
  logic [LSB_W-1:0] lane;
  logic             issue;
  logic             load_issue;

  assign xfer       = req_word ? lsa_pkg::XFER_WORD : lsa_pkg::XFER_BYTE;
  assign load_issue = issue & ~req_store;
  assign mem_req    = issue;

  lsa_lane_dec #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .req_valid (req_valid),
    .req_store (req_store),
    .xfer      (xfer),
    .big_endian(big_endian),
    .ea        (ea),
    .lane      (lane),
    .misalign  (misalign),
    .issue     (issue),
    .wr_en     (mem_be),
    .word_addr (mem_addr)
  );

  lsa_store_path #(.DATA_W(DATA_W)) u_st (
    .xfer   (xfer),
    .st_data(st_data),
    .wdata  (mem_wdata)
  );

  lsa_load_path #(.DATA_W(DATA_W), .LSB_W(LSB_W)) u_ld (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (load_issue),
    .xfer     (xfer),
    .lane     (lane),
    .mem_rdata(mem_rdata),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
  );
endmodule

// File: rtl/lsa_aligner_chk.sv
module lsa_aligner_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_store,
  input logic              req_word,
  input logic [ADDR_W-1:0] ea,
  input logic              mem_req,
  input logic [DATA_W/8-1:0] mem_be,
  input logic              misalign,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data
);
  // R3
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == '0 && !mem_req));

  // R3
  byte_never_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_word) |-> !misalign);

  // R7
  load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |-> (mem_be == '0));

  // R5
  byte_store_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !req_word) |-> ($countones(mem_be) == 1));

  // R2
  word_store_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_word && ea[1:0] == 2'b00) |-> (&mem_be));

  // R10
  load_return_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(req_valid && !req_store && !misalign));

  // R8
  byte_load_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !$past(req_word)) |-> (ld_data[DATA_W-1:8] == '0));

  // R11
  idle_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (ld_data == '0));
endmodule

bind lsa_aligner lsa_aligner_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_store(req_store),
  .req_word (req_word),
  .ea       (ea),
  .mem_req  (mem_req),
  .mem_be   (mem_be),
  .misalign (misalign),
  .ld_valid (ld_valid),
  .ld_data  (ld_data)
);

// File: tb/lsa_aligner_tb.sv
module lsa_aligner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_word = 1'b0, big_endian = 1'b0;
  logic [31:0] ea = '0, st_data = '0, mem_rdata = '0;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic        mem_req, misalign, ld_valid;
  logic [3:0]  mem_be;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state for the load issued in the previous cycle
  bit p_vld = 0, p_word = 0, p_big = 0;
  int p_off = 0;

  always #2 clk = ~clk;

  lsa_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_word(req_word), .big_endian(big_endian), .ea(ea), .st_data(st_data),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_req(mem_req), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit v, input bit st, input bit w, input bit big,
                    input logic [31:0] a, input logic [31:0] d);
    int off, ln;
    bit mis;
    logic [31:0] exp_be, exp_wd, exp_ld, rd;
    string tag;
    @(negedge clk);
    req_valid = v; req_store = st; req_word = w; big_endian = big;
    ea = a; st_data = d; rd = $urandom; mem_rdata = rd;
    #1;
    off = int'(a[1:0]);
    mis = v && w && (off != 0);
    ln  = big ? 3 - off : off;
    if (!v || !st || mis) exp_be = 0;
    else if (w) exp_be = 32'hF;
    else exp_be = 32'h1 << ln;
    tag = mis ? "R3" : (!st ? "R7" : (w ? "R2" : (big ? "R6" : "R5")));
    chk("R1 addr", mem_addr, {a[31:2], 2'b00});
    chk({tag, " be"}, {28'b0, mem_be}, exp_be);
    chk("R3 misalign", {31'b0, misalign}, {31'b0, mis});
    chk(mis ? "R3 req" : "R7 req", {31'b0, mem_req}, {31'b0, v && !mis});
    if (v && st && !mis) begin
      exp_wd = w ? d : {4{d[7:0]}};
      chk(w ? "R2 wdata" : "R4 wdata", mem_wdata, exp_wd);
    end
    chk(p_vld ? "R10 ld_valid" : "R11 ld_valid", {31'b0, ld_valid}, {31'b0, p_vld});
    if (p_vld) begin
      if (p_word) exp_ld = rd;
      else exp_ld = (rd >> (8 * (p_big ? 3 - p_off : p_off))) & 32'hFF;
      chk(p_word ? "R10 ld_data" : (p_big ? "R9 ld_data" : "R8 ld_data"), ld_data, exp_ld);
    end else begin
      chk("R11 ld_data", ld_data, 32'h0);
    end
    p_vld = v && !st && !mis; p_word = w; p_big = big; p_off = off;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 reset ld_valid", {31'b0, ld_valid}, 32'h0);
    chk("R11 reset ld_data", ld_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 R7 R10 aligned words
    op(1, 1, 1, 0, 32'h0000_1000, 32'hDEAD_BEEF);
    op(1, 0, 1, 0, 32'h0000_1004, 32'h0);
    op(1, 0, 1, 1, 32'h0000_2008, 32'h0);
    // R4 R5 R6 byte stores on every offset, both orders
    for (int e = 0; e < 2; e++)
      for (int o = 0; o < 4; o++)
        op(1, 1, 0, e[0], 32'h0000_3000 + o, 32'h1234_56A0 + o);
    // R8 R9 byte loads back to back
    for (int e = 0; e < 2; e++)
      for (int o = 0; o < 4; o++)
        op(1, 0, 0, e[0], 32'h0000_4000 + o, 32'h0);
    // R3 misaligned words, load and store
    for (int o = 1; o < 4; o++) begin
      op(1, 0, 1, 0, 32'h0000_5000 + o, 32'h0);
      op(1, 1, 1, 1, 32'h0000_5000 + o, 32'hCAFE_F00D);
    end
    // idle then load then store gap
    op(0, 0, 1, 0, 32'h0000_0003, 32'h0);
    op(1, 0, 0, 1, 32'hFFFF_FFFF, 32'h0);
    op(1, 1, 0, 0, 32'h8000_0002, 32'h55);
    // mixed random traffic
    for (int i = 0; i < 400; i++)
      op(bit'($urandom_range(0, 7) != 0), bit'($urandom_range(0, 1)),
         bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), $urandom, $urandom);
    op(0, 0, 0, 0, 32'h0, 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule